// File: doc/BRIEF.md
# Detector Mode and Power-Down Controller

This block sits between a 3-bit mode control input and the two receive sections of a caller-identification front end: the FSK demodulator with its carrier detector, and the tone (CAS) detector. It turns the control code into one of three operating modes: FSK receive, tone detect, or power down. It then drives an enable and a synchronous reset to each section, selects the serial interface mode, and sets the status pins that leave the chip.

A control code does not act at once. It must stay on the input for `SETTLE_CYCLES` consecutive clock edges. At 125 MHz the default is about 10 µs. This has two effects. A control bus that passes through the power-down code on its way between two other codes cannot put the device to sleep. Holding a mode for the settle time also works as a reset path: while one section is selected, the other is held in reset for as long as it stays deselected.

Only one part of the code-to-mode mapping is fixed. Bit 0 always picks the interface mode. The power-down code and the tone-select pattern are parameters.

Top module: `detmode_ctrl`

## Requirements
- R1: A new code on `ctl_code` becomes the applied code on the `SETTLE_CYCLES`-th rising clock edge at which it is sampled without a break. One edge earlier, the previously applied code is still in force.
- R2: If a code is held for fewer than `SETTLE_CYCLES` edges and then replaced, it never takes effect. This applies to the power-down code and to any other code.
- R3: With the default parameters, code 3'b111 is power down. Any other code whose bits [2:1] equal 2'b10 (3'b100 and 3'b101) is tone detect. Every remaining code is FSK receive. `pd_active`, `fsk_en` and `tone_en` report the mode.
- R4: `iface_m1` equals bit 0 of the applied code. `sclk_oe` is high exactly when `iface_m1` is low, which is interface mode 0, where the block drives the serial clock.
- R5: In FSK receive, `fsk_en`=1, `fsk_srst`=0, `tone_en`=0 and `tone_srst`=1. With carrier present (`fsk_carrier_n`=0), `sdata_o`, `ready_det_n_o` and `carrier_n_o` follow the FSK section. In mode 0, `sclk_o` also follows the FSK section.
- R6: In tone detect, `tone_en`=1, `tone_srst`=0, `fsk_en`=0 and `fsk_srst`=1. `ready_det_n_o` follows `tone_hit_n`, and `sdata_o`, `sclk_o` and `carrier_n_o` are 1. The FSK inputs have no effect.
- R7: In power down, both enables are 0 and both resets are 1. `sdata_o`, `ready_det_n_o`, `carrier_n_o` and `sclk_o` are 1, and `sclk_oe`=0, whatever the section inputs are.
- R8: In FSK receive, interface mode 0, with carrier absent (`fsk_carrier_n`=1): `sdata_o`, `sclk_o` and `ready_det_n_o` are forced to 1, and `carrier_n_o` is 1.
- R9: In FSK receive, interface mode 1, with carrier absent: `ready_det_n_o` is 1 and `sdata_o` still follows `fsk_data`.
- R10: While `rst_n` is low, and after it until a code has settled, the applied code is the power-down code. The outputs are then as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_code | input | 3 | Mode control code |
| fsk_data | input | 1 | Serial data from the FSK section |
| fsk_ready_n | input | 1 | Byte-ready from the FSK section, active low |
| fsk_clk_out | input | 1 | Serial clock from the FSK section (mode 0) |
| fsk_carrier_n | input | 1 | Carrier detect from the FSK section, active low |
| tone_hit_n | input | 1 | Tone detect from the tone section, active low |
| fsk_en | output | 1 | FSK section enable |
| fsk_srst | output | 1 | FSK section synchronous reset |
| tone_en | output | 1 | Tone section enable |
| tone_srst | output | 1 | Tone section synchronous reset |
| iface_m1 | output | 1 | Serial interface mode 1 selected |
| pd_active | output | 1 | Power down in force |
| sdata_o | output | 1 | Serial data pin value |
| sclk_o | output | 1 | Serial clock pin value (mode 0) |
| sclk_oe | output | 1 | Serial clock pin output enable |
| ready_det_n_o | output | 1 | Shared data-ready / tone-detect pin, active low |
| carrier_n_o | output | 1 | Carrier detect pin, active low |

## Verification
The bench drives a code on a falling edge and counts the rising edges that follow. It checks the old mode after `SETTLE_CYCLES`-1 edges and the new mode after `SETTLE_CYCLES` edges, because the applied code register is the only register on that path. The status pins depend combinationally on the applied mode and the section inputs. So the bench changes a section input on a falling edge and samples one time unit later, within the same low phase. For glitch scenarios, the bench holds a code for exactly one edge less than the settle time, reverts it, and samples every low phase to confirm that no mode output ever moved.

// File: rtl/detmode_pkg.sv
package detmode_pkg;

    typedef enum logic [1:0] {
        MODE_FSK  = 2'd0,
        MODE_TONE = 2'd1,
        MODE_OFF  = 2'd2
    } det_mode_e;

    typedef struct packed {
        det_mode_e mode;
        logic      fsk_en;
        logic      fsk_srst;
        logic      tone_en;
        logic      tone_srst;
        logic      iface_m1;
        logic      pd_active;
    } mode_ctl_t;

endpackage

// File: rtl/detmode_filter.sv
module detmode_filter #(
    parameter int          CODE_W        = 3,
    parameter int          SETTLE_CYCLES = 1250,
    parameter logic [CODE_W-1:0] RESET_CODE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int CNT_W = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(SETTLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 2);

    typedef struct packed {
        logic [CODE_W-1:0] samp;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] applied;
    } flt_t;

    flt_t flt_q, flt_d;

    always_comb begin
        flt_d = flt_q;
        if (code_i != flt_q.samp) begin
            // new candidate: restart the stability run
            flt_d.samp = code_i;
            flt_d.cnt  = '0;
        end else if (flt_q.cnt != CNT_TOP) begin
            flt_d.cnt = flt_q.cnt + 1'b1;
            if (flt_q.cnt == CNT_LAST) begin
                flt_d.applied = code_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_q.samp    <= RESET_CODE;
            flt_q.cnt     <= '0;
            flt_q.applied <= RESET_CODE;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign code_o = flt_q.applied;
endmodule

// File: rtl/detmode_decode.sv
module detmode_decode
    import detmode_pkg::*;
#(
    parameter int                CODE_W   = 3,
    parameter logic [CODE_W-1:0] PD_CODE  = '1,
    parameter logic [CODE_W-2:0] TONE_SEL = '0
) (
    input  logic [CODE_W-1:0] code_i,
    output mode_ctl_t         ctl_o
);
    always_comb begin
        ctl_o          = '0;
        ctl_o.iface_m1 = code_i[0];
        if (code_i == PD_CODE) begin
            ctl_o.mode = MODE_OFF;
        end else if (code_i[CODE_W-1:1] == TONE_SEL) begin
            ctl_o.mode = MODE_TONE;
        end else begin
            ctl_o.mode = MODE_FSK;
        end
        ctl_o.pd_active = (ctl_o.mode == MODE_OFF);
        ctl_o.fsk_en    = (ctl_o.mode == MODE_FSK);
        ctl_o.tone_en   = (ctl_o.mode == MODE_TONE);
        ctl_o.fsk_srst  = (ctl_o.mode != MODE_FSK);
        ctl_o.tone_srst = (ctl_o.mode != MODE_TONE);
    end
endmodule

// File: rtl/detmode_outmux.sv
module detmode_outmux
    import detmode_pkg::*;
(
    input  det_mode_e mode_i,
    input  logic      iface_m1_i,
    input  logic      fsk_data,
    input  logic      fsk_ready_n,
    input  logic      fsk_clk_out,
    input  logic      fsk_carrier_n,
    input  logic      tone_hit_n,
    output logic      sdata_o,
    output logic      sclk_o,
    output logic      sclk_oe,
    output logic      ready_det_n_o,
    output logic      carrier_n_o
);
    always_comb begin
        sdata_o       = 1'b1;
        sclk_o        = 1'b1;
        ready_det_n_o = 1'b1;
        carrier_n_o   = 1'b1;
        sclk_oe       = (mode_i != MODE_OFF) && !iface_m1_i;
        unique case (mode_i)
            MODE_FSK: begin
                carrier_n_o = fsk_carrier_n;
                if (!fsk_carrier_n) begin
                    sdata_o       = fsk_data;
                    ready_det_n_o = fsk_ready_n;
                    sclk_o        = iface_m1_i ? 1'b1 : fsk_clk_out;
                end else if (iface_m1_i) begin
                    sdata_o = fsk_data;
                end
            end
            MODE_TONE: ready_det_n_o = tone_hit_n;
            default: ;
        endcase
    end
endmodule

// File: rtl/detmode_ctrl.sv
module detmode_ctrl
    import detmode_pkg::*;
#(
    parameter int                CODE_W        = 3,
    parameter int                SETTLE_CYCLES = 1250,
    parameter logic [CODE_W-1:0] PD_CODE       = 3'b111,
    parameter logic [CODE_W-2:0] TONE_SEL      = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ctl_code,
    input  logic              fsk_data,
    input  logic              fsk_ready_n,
    input  logic              fsk_clk_out,
    input  logic              fsk_carrier_n,
    input  logic              tone_hit_n,
    output logic              fsk_en,
    output logic              fsk_srst,
    output logic              tone_en,
    output logic              tone_srst,
    output logic              iface_m1,
    output logic              pd_active,
    output logic              sdata_o,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              ready_det_n_o,
    output logic              carrier_n_o
);
    logic [CODE_W-1:0] applied_code;
    mode_ctl_t         ctl;

    detmode_filter #(
        .CODE_W        (CODE_W),
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .RESET_CODE    (PD_CODE)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_i (ctl_code),
        .code_o (applied_code)
    );

    detmode_decode #(
        .CODE_W   (CODE_W),
        .PD_CODE  (PD_CODE),
        .TONE_SEL (TONE_SEL)
    ) u_decode (
        .code_i (applied_code),
        .ctl_o  (ctl)
    );

    detmode_outmux u_outmux (
        .mode_i        (ctl.mode),
        .iface_m1_i    (ctl.iface_m1),
        .fsk_data      (fsk_data),
        .fsk_ready_n   (fsk_ready_n),
        .fsk_clk_out   (fsk_clk_out),
        .fsk_carrier_n (fsk_carrier_n),
        .tone_hit_n    (tone_hit_n),
        .sdata_o       (sdata_o),
        .sclk_o        (sclk_o),
        .sclk_oe       (sclk_oe),
        .ready_det_n_o (ready_det_n_o),
        .carrier_n_o   (carrier_n_o)
    );

    assign fsk_en    = ctl.fsk_en;
    assign fsk_srst  = ctl.fsk_srst;
    assign tone_en   = ctl.tone_en;
    assign tone_srst = ctl.tone_srst;
    assign iface_m1  = ctl.iface_m1;
    assign pd_active = ctl.pd_active;
endmodule

// File: rtl/detmode_ctrl_chk.sv
module detmode_ctrl_chk #(
    parameter int                CODE_W        = 3,
    parameter int                SETTLE_CYCLES = 1250,
    parameter logic [CODE_W-1:0] PD_CODE       = 3'b111
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] ctl_code,
    input logic              fsk_carrier_n,
    input logic              fsk_en,
    input logic              fsk_srst,
    input logic              tone_en,
    input logic              tone_srst,
    input logic              iface_m1,
    input logic              pd_active,
    input logic              sdata_o,
    input logic              sclk_o,
    input logic              sclk_oe,
    input logic              ready_det_n_o,
    input logic              carrier_n_o
);
    initial begin
        // R1: the settle window must span at least two edges
        settle_min_chk: assert (SETTLE_CYCLES >= 2);
        // R4: power-down code must select interface mode 1
        pd_bit0_chk: assert (PD_CODE[0] == 1'b1);
    end

    // R1
    settle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed({pd_active, fsk_en, tone_en, iface_m1}))
            |-> ($past(ctl_code) == $past(ctl_code, 2)));

    // R7
    pd_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |-> (sdata_o && ready_det_n_o && carrier_n_o && sclk_o
                       && !sclk_oe && fsk_srst && tone_srst));

    // R6
    tone_holds_fsk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tone_en |-> (fsk_srst && !fsk_en && carrier_n_o && sdata_o));

    // R5
    fsk_holds_tone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsk_en |-> (tone_srst && !tone_en));

    // R8
    mode0_no_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsk_en && !iface_m1 && fsk_carrier_n)
            |-> (sdata_o && sclk_o && ready_det_n_o && carrier_n_o));
endmodule

bind detmode_ctrl detmode_ctrl_chk #(
    .CODE_W        (CODE_W),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .PD_CODE       (PD_CODE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_code      (ctl_code),
    .fsk_carrier_n (fsk_carrier_n),
    .fsk_en        (fsk_en),
    .fsk_srst      (fsk_srst),
    .tone_en       (tone_en),
    .tone_srst     (tone_srst),
    .iface_m1      (iface_m1),
    .pd_active     (pd_active),
    .sdata_o       (sdata_o),
    .sclk_o        (sclk_o),
    .sclk_oe       (sclk_oe),
    .ready_det_n_o (ready_det_n_o),
    .carrier_n_o   (carrier_n_o)
);

// File: tb/detmode_ctrl_bench.sv
`timescale 1ns/1ps
module detmode_ctrl_bench;
    localparam int S = 1250;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] ctl_code;
    logic       fsk_data, fsk_ready_n, fsk_clk_out, fsk_carrier_n, tone_hit_n;
    logic       fsk_en, fsk_srst, tone_en, tone_srst, iface_m1, pd_active;
    logic       sdata_o, sclk_o, sclk_oe, ready_det_n_o, carrier_n_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    detmode_ctrl #(.SETTLE_CYCLES(S)) u_detmode_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_code(ctl_code),
        .fsk_data(fsk_data), .fsk_ready_n(fsk_ready_n), .fsk_clk_out(fsk_clk_out),
        .fsk_carrier_n(fsk_carrier_n), .tone_hit_n(tone_hit_n),
        .fsk_en(fsk_en), .fsk_srst(fsk_srst), .tone_en(tone_en), .tone_srst(tone_srst),
        .iface_m1(iface_m1), .pd_active(pd_active), .sdata_o(sdata_o), .sclk_o(sclk_o),
        .sclk_oe(sclk_oe), .ready_det_n_o(ready_det_n_o), .carrier_n_o(carrier_n_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // {fsk_en, fsk_srst, tone_en, tone_srst, iface_m1, pd_active, sclk_oe}
    function automatic logic [6:0] ctl_vec();
        return {fsk_en, fsk_srst, tone_en, tone_srst, iface_m1, pd_active, sclk_oe};
    endfunction

    // {sdata_o, sclk_o, ready_det_n_o, carrier_n_o}
    function automatic logic [3:0] pin_vec();
        return {sdata_o, sclk_o, ready_det_n_o, carrier_n_o};
    endfunction

    function automatic logic [6:0] exp_ctl(input logic [2:0] c);
        logic pd, tn, fk;
        pd = (c == 3'b111);
        tn = !pd && (c[2:1] == 2'b10);
        fk = !pd && !tn;
        return {fk, !fk, tn, !tn, c[0], pd, !pd && !c[0]};
    endfunction

    task automatic apply_code(input logic [2:0] c);
        @(negedge clk);
        ctl_code = c;
        repeat (S) @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        ctl_code = 3'b000;
        repeat (5) @(negedge clk);
        #1;
        chk("R10 ctl in reset", 16'(ctl_vec()), 16'(exp_ctl(3'b111)));
        chk("R10 pins in reset", 16'(pin_vec()), 16'hF);
        @(negedge clk);
        ctl_code = 3'b111;
        rst_n = 1'b1;
        #1;
        chk("R10 ctl after reset", 16'(ctl_vec()), 16'(exp_ctl(3'b111)));
    endtask

    task automatic t_settle();
        @(negedge clk);
        ctl_code = 3'b000;
        repeat (S - 1) @(negedge clk);
        #1;
        chk("R1 old mode one edge early", 16'(pd_active), 16'd1);
        @(negedge clk);
        #1;
        chk("R1 new mode on settle edge", 16'(ctl_vec()), 16'(exp_ctl(3'b000)));
    endtask

    task automatic t_glitch();
        bit moved;
        moved = 1'b0;
        @(negedge clk);
        ctl_code = 3'b111;
        repeat (S - 1) begin
            @(negedge clk);
            #1;
            if (pd_active || !fsk_en) moved = 1'b1;
        end
        ctl_code = 3'b000;
        repeat (S) begin
            @(negedge clk);
            #1;
            if (pd_active || !fsk_en) moved = 1'b1;
        end
        chk("R2 brief power-down code ignored", 16'(moved), 16'd0);
        moved = 1'b0;
        ctl_code = 3'b100;
        repeat (S - 1) begin
            @(negedge clk);
            #1;
            if (tone_en) moved = 1'b1;
        end
        ctl_code = 3'b000;
        repeat (S) begin
            @(negedge clk);
            #1;
            if (tone_en) moved = 1'b1;
        end
        chk("R2 brief tone code ignored", 16'(moved), 16'd0);
        chk("R2 mode unchanged", 16'(ctl_vec()), 16'(exp_ctl(3'b000)));
    endtask

    task automatic t_decode();
        for (int i = 0; i < 8; i++) begin
            apply_code(3'(i));
            chk($sformatf("R3 R4 decode code %0d", i), 16'(ctl_vec()), 16'(exp_ctl(3'(i))));
        end
    endtask

    task automatic t_fsk();
        apply_code(3'b000);
        fsk_data = 1'b0; fsk_ready_n = 1'b0; fsk_clk_out = 1'b0; fsk_carrier_n = 1'b0;
        #1;
        chk("R5 mode0 carrier pass", 16'(pin_vec()), 16'h0);
        fsk_data = 1'b1; fsk_clk_out = 1'b1;
        #1;
        chk("R5 mode0 follows section", 16'(pin_vec()), 16'hC);
        fsk_data = 1'b0; fsk_clk_out = 1'b0; fsk_carrier_n = 1'b1;
        #1;
        chk("R8 mode0 no carrier forced high", 16'(pin_vec()), 16'hF);
        apply_code(3'b001);
        fsk_carrier_n = 1'b0;
        #1;
        chk("R5 mode1 carrier pass", 16'(pin_vec()), 16'h4);
        chk("R4 mode1 no clock drive", 16'(sclk_oe), 16'd0);
        fsk_carrier_n = 1'b1;
        #1;
        chk("R9 mode1 no carrier", 16'(pin_vec()), 16'h7);
        fsk_data = 1'b1;
        #1;
        chk("R9 mode1 data passes", 16'(sdata_o), 16'd1);
        fsk_data = 1'b0; fsk_carrier_n = 1'b0;
    endtask

    task automatic t_tone();
        apply_code(3'b100);
        tone_hit_n = 1'b0;
        #1;
        chk("R6 tone ctl", 16'(ctl_vec()), 16'(exp_ctl(3'b100)));
        chk("R6 tone detect low", 16'(pin_vec()), 16'hD);
        tone_hit_n = 1'b1; fsk_ready_n = 1'b0;
        #1;
        chk("R6 fsk ready ignored", 16'(pin_vec()), 16'hF);
        tone_hit_n = 1'b0;
    endtask

    task automatic t_pd();
        apply_code(3'b111);
        fsk_data = 1'b0; fsk_ready_n = 1'b0; fsk_clk_out = 1'b0;
        fsk_carrier_n = 1'b0; tone_hit_n = 1'b0;
        #1;
        chk("R7 pd ctl", 16'(ctl_vec()), 16'(exp_ctl(3'b111)));
        chk("R7 pd pins high", 16'(pin_vec()), 16'hF);
    endtask

    initial begin
        fsk_data = 1'b0; fsk_ready_n = 1'b0; fsk_clk_out = 1'b0;
        fsk_carrier_n = 1'b0; tone_hit_n = 1'b0;
        t_reset();
        t_settle();
        t_glitch();
        t_decode();
        t_fsk();
        t_tone();
        t_pd();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule